// File: doc/BRIEF.md
# Periodic Impedance Calibration Scheduler

This block decides when a memory channel pauses to recalibrate its output drivers and termination. It counts refresh-interval ticks. Once a programmed number of them has been seen, it opens a calibration window: for a programmed number of memory clocks it asserts a command-block signal, which stalls the channel's command scheduler. Inside that window it issues two single-cycle strobes. The first tells the command-path calibration logic to apply its update, at a programmable offset from the start of the window. The second tells the data-path calibration logic to apply its update, on the last blocked clock.

The configuration (enable, gap in refresh intervals, window length, command-update offset) arrives as plain inputs from a register block that sits elsewhere. The block copies the window parameters when a window opens, so software may reprogram them at any time without corrupting a window that is already running. Typical programming is a window of 31 clocks with the command update at offset 15. The register defaults are a window of 9 with offset 2, enable set and a gap field of 0.

Top module: `ical_scheduler`

## Requirements
- R1: After reset, `cmdBlock`, `cmdCalPulse` and `dataCalPulse` are low, and the refresh-tick count is zero.
- R2: With the block enabled and no window running, a refresh tick is accepted. The accepted tick that brings the count since reset, or since the last window start, to `cfgInterval`+1 starts a window, and the count then restarts from zero. A gap field of 0 therefore opens a window on every accepted tick. If `cfgInterval` is lowered below the current count, the next accepted tick starts a window.
- R3: A window raises `cmdBlock` in the cycle after the starting tick and holds it high for exactly `cfgLength` consecutive cycles. A length of 0 produces no blocking and no pulses, but the tick count still restarts.
- R4: `cmdCalPulse` is high for one cycle, in the window cycle whose offset equals `cfgCmdDelay`, where offset 0 is the first blocked cycle. If `cfgCmdDelay` is not less than the window length, the pulse does not appear.
- R5: `dataCalPulse` is high for one cycle, on the last blocked cycle of each window. When `cfgCmdDelay` equals the length minus one, both pulses are high in that same cycle.
- R6: While `cfgEnable` is low, refresh ticks are ignored, no window starts and the tick count is held at zero. A window that is already running completes.
- R7: Length and command offset are captured when a window starts. Changing them during a window does not alter that window.
- R8: Refresh ticks that arrive while a window is running are neither counted nor able to start a window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Memory clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| refreshTick | input | 1 | Single-cycle pulse once per refresh interval |
| cfgEnable | input | 1 | Enables calibration scheduling |
| cfgInterval | input | 4 | Gap between windows, in refresh intervals, minus one |
| cfgLength | input | 6 | Window length in memory clocks |
| cfgCmdDelay | input | 6 | Offset of the command update pulse within the window |
| cmdBlock | output | 1 | High while all commands must be held off |
| cmdCalPulse | output | 1 | One-cycle command-path calibration update strobe |
| dataCalPulse | output | 1 | One-cycle data-path calibration update strobe |

## Verification
The command-update strobe and the data-update strobe can land in the same cycle. This happens when the programmed offset equals the window length minus one, and it also happens in a one-clock window with offset zero. The bench programs both of these cases. Its per-cycle scoreboard expects both strobes high, together with `cmdBlock`, in exactly that last blocked cycle and low in every cycle around it. A further case sets the offset just past the last cycle, and there only the data strobe may appear.

// File: rtl/ical_pkg.sv
package ical_pkg;
  localparam int unsigned INT_W = 4;
  localparam int unsigned LEN_W = 6;

  typedef struct packed {
    logic startWin;
    logic tickTaken;
  } icalStrobe_t;
endpackage

// File: rtl/ical_ctrl.sv
module ical_ctrl
  import ical_pkg::*;
#(
  parameter int unsigned IW = INT_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          refreshTick,
  input  logic          cfgEnable,
  input  logic [IW-1:0] cfgInterval,
  input  logic          winBusy,
  output icalStrobe_t   strb
);
  logic [IW-1:0] tickCnt;
  logic          gapReached;

  assign gapReached     = (tickCnt >= cfgInterval);
  assign strb.tickTaken = cfgEnable && refreshTick && !winBusy;
  assign strb.startWin  = strb.tickTaken && gapReached;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tickCnt <= '0;
    end else if (!cfgEnable) begin
      tickCnt <= '0;
    end else if (strb.tickTaken) begin
      if (gapReached) tickCnt <= '0;
      else            tickCnt <= tickCnt + 1'b1;
    end
  end

  // R2: the count restarts from zero after every window start
  p_reload_on_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
    strb.startWin |=> (tickCnt == '0));

  // R8: a tick that arrives during a window leaves the count unchanged
  p_busy_tick_ignored_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (winBusy && cfgEnable) |=> $stable(tickCnt));

  // R6: while disabled the count sits at zero
  p_disabled_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !cfgEnable |=> (tickCnt == '0));
endmodule

// File: rtl/ical_window.sv
module ical_window
  import ical_pkg::*;
#(
  parameter int unsigned LW = LEN_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  icalStrobe_t   strb,
  input  logic [LW-1:0] cfgLength,
  input  logic [LW-1:0] cfgCmdDelay,
  output logic          winBusy,
  output logic          cmdCalPulse,
  output logic          dataCalPulse
);
  logic          active;
  logic [LW-1:0] posCnt;
  logic [LW-1:0] lenQ;
  logic [LW-1:0] dlyQ;
  logic          lastBeat;

  assign lastBeat     = (posCnt == (lenQ - LW'(1)));
  assign winBusy      = active;
  assign dataCalPulse = active && lastBeat;
  assign cmdCalPulse  = active && (posCnt == dlyQ);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0;
      posCnt <= '0;
      lenQ   <= '0;
      dlyQ   <= '0;
    end else if (strb.startWin) begin
      active <= (cfgLength != '0);
      posCnt <= '0;
      lenQ   <= cfgLength;
      dlyQ   <= cfgCmdDelay;
    end else if (active) begin
      if (lastBeat) active <= 1'b0;
      else          posCnt <= posCnt + 1'b1;
    end
  end

  // R3: length of each blocking run, measured independently
  logic [LW:0] runLen;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      runLen <= '0;
    else if (active) runLen <= runLen + 1'b1;
    else             runLen <= '0;
  end

  p_run_length_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(active) |-> (runLen == {1'b0, lenQ}));

  // R4: the command strobe never lasts two cycles
  p_cmd_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cmdCalPulse |=> !cmdCalPulse);

  // R7: captured parameters hold steady while a window runs
  p_cfg_held_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !strb.startWin) |=> ($stable(lenQ) && $stable(dlyQ)));
endmodule

// File: rtl/ical_scheduler.sv
module ical_scheduler
  import ical_pkg::*;
#(
  parameter int unsigned IW = INT_W,
  parameter int unsigned LW = LEN_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          refreshTick,
  input  logic          cfgEnable,
  input  logic [IW-1:0] cfgInterval,
  input  logic [LW-1:0] cfgLength,
  input  logic [LW-1:0] cfgCmdDelay,
  output logic          cmdBlock,
  output logic          cmdCalPulse,
  output logic          dataCalPulse
);
  icalStrobe_t strb;
  logic        winBusy;

  ical_ctrl #(.IW(IW)) ctrl_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .refreshTick (refreshTick),
    .cfgEnable   (cfgEnable),
    .cfgInterval (cfgInterval),
    .winBusy     (winBusy),
    .strb        (strb)
  );

  ical_window #(.LW(LW)) win_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .strb         (strb),
    .cfgLength    (cfgLength),
    .cfgCmdDelay  (cfgCmdDelay),
    .winBusy      (winBusy),
    .cmdCalPulse  (cmdCalPulse),
    .dataCalPulse (dataCalPulse)
  );

  assign cmdBlock = winBusy;

  // R6: a window only opens on a tick seen while enabled
  p_open_needs_enable_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cmdBlock) |-> $past(cfgEnable && refreshTick));

  // R4: the command strobe stays inside the blocking window
  p_cmd_inside_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cmdCalPulse |-> cmdBlock);

  // R5: the data strobe marks the final blocked cycle
  p_data_last_r5: assert property (@(posedge clk) disable iff (!rst_n)
    dataCalPulse |=> !cmdBlock);

  p_fall_after_data_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cmdBlock) |-> $past(dataCalPulse));
endmodule

// File: tb/ical_scheduler_tb.sv
module ical_scheduler_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       refreshTick = 1'b0;
  logic       cfgEnable = 1'b1;
  logic [3:0] cfgInterval = 4'd0;
  logic [5:0] cfgLength = 6'd9;
  logic [5:0] cfgCmdDelay = 6'd2;
  logic       cmdBlock, cmdCalPulse, dataCalPulse;

  always #2.5 clk = ~clk;

  ical_scheduler dut_i (
    .clk(clk), .rst_n(rst_n), .refreshTick(refreshTick),
    .cfgEnable(cfgEnable), .cfgInterval(cfgInterval),
    .cfgLength(cfgLength), .cfgCmdDelay(cfgCmdDelay),
    .cmdBlock(cmdBlock), .cmdCalPulse(cmdCalPulse),
    .dataCalPulse(dataCalPulse)
  );

  typedef struct { int start; int len; int dly; } win_t;
  win_t expQ[$];

  int checks = 0;
  int failures = 0;
  int cyc = 0;
  int modelCnt = 0;
  int busyEnd = 0;
  bit monOn = 0;
  bit finished = 0;
  string scen = "R1";

  always @(posedge clk) cyc <= cyc + 1;

  // Monitor: compare every cycle against the expected window at queue head
  always @(negedge clk) begin
    if (monOn) begin
      bit eb, ec, ed;
      bit popIt;
      int off;
      eb = 0; ec = 0; ed = 0; popIt = 0;
      if (expQ.size() > 0 && cyc >= expQ[0].start) begin
        off = cyc - expQ[0].start;
        eb = 1;
        ec = (off == expQ[0].dly);
        ed = (off == expQ[0].len - 1);
        popIt = ed;
      end
      checks++;
      if (cmdBlock !== eb) begin
        failures++;
        $display("FAIL R3 [%s] cyc=%0d cmdBlock actual=%b expected=%b", scen, cyc, cmdBlock, eb);
      end else if (cmdCalPulse !== ec) begin
        failures++;
        $display("FAIL R4 [%s] cyc=%0d cmdCalPulse actual=%b expected=%b", scen, cyc, cmdCalPulse, ec);
      end else if (dataCalPulse !== ed) begin
        failures++;
        $display("FAIL R5 [%s] cyc=%0d dataCalPulse actual=%b expected=%b", scen, cyc, dataCalPulse, ed);
      end
      if (popIt) void'(expQ.pop_front());
    end
  end

  // Driver: one refresh tick, with the reference model of R2, R6, R8
  task automatic sendTick();
    refreshTick = 1'b1;
    if (cfgEnable && cyc >= busyEnd) begin
      if (modelCnt >= int'(cfgInterval)) begin
        modelCnt = 0;
        if (cfgLength != 0) begin
          win_t w;
          w.start = cyc + 1;
          w.len = int'(cfgLength);
          w.dly = int'(cfgCmdDelay);
          expQ.push_back(w);
          busyEnd = cyc + 1 + w.len;
        end
      end else begin
        modelCnt++;
      end
    end
    @(negedge clk);
    refreshTick = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic setCfg(input int iv, input int ln, input int dl);
    cfgInterval = 4'(iv);
    cfgLength = 6'(ln);
    cfgCmdDelay = 6'(dl);
  endtask

  task automatic setEnable(input bit e);
    cfgEnable = e;
    if (!e) modelCnt = 0;
  endtask

  initial begin
    // R1: reset state
    idle(3);
    checks++;
    if ({cmdBlock, cmdCalPulse, dataCalPulse} !== 3'b000) begin
      failures++;
      $display("FAIL R1 outputs in reset actual=%b expected=000", {cmdBlock, cmdCalPulse, dataCalPulse});
    end
    rst_n = 1'b1;
    monOn = 1;
    idle(4);

    // R2/R3/R4/R5: default-style programming, gap of one interval
    scen = "R2";
    setCfg(0, 9, 2);
    sendTick(); idle(14);

    // R2: gap of three intervals
    setCfg(2, 5, 1);
    sendTick(); idle(6);
    sendTick(); idle(6);
    sendTick(); idle(10);

    // R3/R4: recommended programming
    scen = "R3";
    setCfg(0, 31, 15);
    sendTick(); idle(36);

    // R5: both strobes in the same last cycle
    scen = "R5";
    setCfg(0, 4, 3);
    sendTick(); idle(8);
    setCfg(0, 1, 0);
    sendTick(); idle(5);

    // R4: offset beyond window, command strobe suppressed
    scen = "R4";
    setCfg(0, 3, 3);
    sendTick(); idle(6);
    setCfg(0, 3, 40);
    sendTick(); idle(6);

    // R3: zero length window restarts count but blocks nothing
    scen = "R3";
    setCfg(1, 0, 0);
    sendTick(); idle(3);
    sendTick(); idle(3);
    setCfg(1, 5, 2);
    sendTick(); idle(3);
    sendTick(); idle(9);

    // R6: disabled ticks ignored; count cleared by disable
    scen = "R6";
    setCfg(1, 6, 1);
    sendTick(); idle(3);
    setEnable(0); idle(2);
    sendTick(); idle(2); sendTick(); idle(2);
    setEnable(1); idle(1);
    sendTick(); idle(4);
    sendTick(); idle(2);
    setEnable(0); idle(10);
    setEnable(1); idle(2);

    // R7: reprogramming mid-window does not alter it
    scen = "R7";
    setCfg(0, 10, 4);
    sendTick(); idle(1);
    setCfg(0, 2, 0);
    idle(14);
    sendTick(); idle(5);

    // R8: ticks inside a window are not counted; lowered gap
    scen = "R8";
    setCfg(0, 10, 3);
    sendTick(); idle(2);
    sendTick(); idle(2);
    sendTick(); idle(12);
    setCfg(1, 4, 1);
    sendTick(); idle(2);
    sendTick(); idle(2);
    sendTick(); idle(8);
    setCfg(3, 4, 2);
    sendTick(); idle(2);
    setCfg(0, 4, 2);
    sendTick(); idle(8);

    checks++;
    if (expQ.size() != 0) begin
      failures++;
      $display("FAIL R2 pending windows actual=%0d expected=0", expQ.size());
    end
    finished = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL R2 watchdog expired actual=running expected=done");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule